// File: doc/BRIEF.md
# Clock-Control Register Bank

This block is the software-visible register bank of a clock-control unit. A host reaches it over a plain 32-bit word bus. The bus carries a word index, a write strobe with write data, and a read strobe with registered read data. The bank holds nine registers:

- one mode word
- two post-divider words
- two PLL control words
- three clock-gating words
- one power-management word

Each writable register keeps only its own writable bits. The mode word also sets one bit on every write.

Downstream frequency logic reads the mode, first post-divider and main PLL words straight from dedicated outputs. It recomputes its clock rates when `clk_update_o` pulses. That pulse follows each write that can change a clock rate, and it also fires once when the bank leaves reset. Gating writes never raise it. One index returns a fixed identification constant. All other unmapped indices read zero and ignore writes.

Top module: `clkctl_regs`

## Requirements
- R1: After reset the registers read as follows:
  - mode (index 0): 0x074B0B7B
  - post-divider A (index 1): 0xFF870B48
  - post-divider B (index 2): 0x49FCFE7F
  - main PLL (index 4): 0x04001800
  - auxiliary PLL (index 6): 0x04043001
  - gating words (indices 8, 9, 10): 0xFFFFFFFF
  - power word (index 23): 0x80209828

  `rdata_o` is 0 and `clk_update_o` is 0 while reset is held.
- R2: A write to index 0 stores (wdata & 0x3B6FDFFF) | 0x04000000, so bit 26 of the mode word is always 1.
- R3: A write to index 1 stores wdata & 0xFF9F3FFF. A write to index 2 stores all 32 bits.
- R4: A write to index 4 or 6 stores wdata & 0xBFFF3FFF. PLL words pack pre-divider [29:26], denominator [25:16], integer [13:10] and numerator [9:0].
- R5: Writes to indices 8, 9 and 10 store all 32 bits and do not raise `clk_update_o`.
- R6: Index 18 always reads 0x00004040, and a write to it changes nothing.
- R7: Any index other than 0, 1, 2, 4, 6, 8, 9, 10, 18 and 23 reads 0. A write to such an index changes no register and raises no pulse.
- R8: Index 23 is read-only. A write to it leaves it at its reset value.
- R9: `rdata_o` is loaded on the clock edge that samples `re_i`, from register contents before any write in that same cycle. It holds its value while `re_i` is low.
- R10: A write to index 0, 1, 2, 4 or 6 makes `clk_update_o` high for the one cycle after the write edge. This is the same edge on which the new value appears on `mode_o`, `post_div0_o` and `main_pll_o`.
- R11: `clk_update_o` is high for exactly one cycle after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 10 | Word index (byte address bits 11:2) |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| clk_update_o | output | 1 | One-cycle clock-recompute request |
| mode_o | output | 32 | Current mode word |
| post_div0_o | output | 32 | Current post-divider A word |
| main_pll_o | output | 32 | Current main PLL word |

## Verification
A wrong mask or a wrong reset constant shows on `rdata_o` on the first read of that index, one edge after the read strobe. The same fault shows on the dedicated outputs as soon as the write edge has passed. A decode fault makes a write land in the wrong slot or in no slot. The bench keeps a model of every index, so the fault appears on the next read of either index. Misclassifying which writes recompute clocks shows on `clk_update_o` in the cycle right after the offending write.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DW       = 32;
  localparam int NREG     = 9;
  localparam int ID_IDX   = 18;
  localparam logic [DW-1:0] ID_VAL = 32'h0000_4040;
  localparam int MODE_FORCE_BIT = 26;

  localparam int S_MODE = 0;
  localparam int S_DIVA = 1;
  localparam int S_DIVB = 2;
  localparam int S_PLLM = 3;
  localparam int S_PLLA = 4;
  localparam int S_GT0  = 5;
  localparam int S_GT1  = 6;
  localparam int S_GT2  = 7;
  localparam int S_PWR  = 8;

  function automatic logic [DW-1:0] pll_pack(int unsigned pd, int unsigned den,
                                             int unsigned ip, int unsigned num);
    logic [DW-1:0] v;
    v = '0;
    v[29:26] = pd[3:0];
    v[25:16] = den[9:0];
    v[13:10] = ip[3:0];
    v[9:0]   = num[9:0];
    return v;
  endfunction

  function automatic int slot_index(int s);
    case (s)
      S_MODE: return 0;
      S_DIVA: return 1;
      S_DIVB: return 2;
      S_PLLM: return 4;
      S_PLLA: return 6;
      S_GT0:  return 8;
      S_GT1:  return 9;
      S_GT2:  return 10;
      default: return 23;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_rst(int s);
    case (s)
      S_MODE: return 32'h074B_0B7B;
      S_DIVA: return 32'hFF87_0B48;
      S_DIVB: return 32'h49FC_FE7F;
      S_PLLM: return pll_pack(1, 0, 6, 0);
      S_PLLA: return pll_pack(1, 4, 12, 1);
      S_PWR:  return 32'h8020_9828;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_wmask(int s);
    case (s)
      S_MODE: return 32'h3B6F_DFFF;
      S_DIVA: return 32'hFF9F_3FFF;
      S_PLLM, S_PLLA: return 32'hBFFF_3FFF;
      S_PWR:  return 32'h0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_setmask(int s);
    return (s == S_MODE) ? (32'h1 << MODE_FORCE_BIT) : 32'h0;
  endfunction

  function automatic bit slot_writable(int s);
    return s != S_PWR;
  endfunction

  function automatic logic [NREG-1:0] recompute_mask();
    logic [NREG-1:0] m;
    m = '0;
    m[S_MODE] = 1'b1;
    m[S_DIVA] = 1'b1;
    m[S_DIVB] = 1'b1;
    m[S_PLLM] = 1'b1;
    m[S_PLLA] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
#(
  parameter int IW = 10
) (
  input  logic [IW-1:0]   idx_i,
  output logic [NREG-1:0] hit_o,
  output logic            id_hit_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit_o[g] = (idx_i == IW'(slot_index(g)));
  end
  assign id_hit_o = (idx_i == IW'(ID_IDX));
endmodule

// File: rtl/clkctl_slot_reg.sv
module clkctl_slot_reg #(
  parameter int DW = 32,
  parameter logic [DW-1:0] RST   = '0,
  parameter logic [DW-1:0] WMASK = '1,
  parameter logic [DW-1:0] SETM  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (wr_i) q_o <= (wdata_i & WMASK) | SETM;
  end

  // R2 R3 R4: writable bits follow the written data
  a_r3_masked_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o & WMASK & ~SETM) == ($past(wdata_i) & WMASK & ~SETM)));
  // R2: forced bits are set after every write
  a_r2_forced_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o & SETM) == SETM));
endmodule

// File: rtl/clkctl_rdmux.sv
module clkctl_rdmux
  import clkctl_pkg::*;
(
  input  logic [NREG-1:0]         hit_i,
  input  logic                    id_hit_i,
  input  logic [NREG-1:0][DW-1:0] q_i,
  output logic [DW-1:0]           rdata_o
);
  always_comb begin
    rdata_o = id_hit_i ? ID_VAL : '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_i[i]) rdata_o = rdata_o | q_i[i];
    end
  end
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:2] addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  input  logic          re_i,
  output logic [31:0]   rdata_o,
  output logic          clk_update_o,
  output logic [31:0]   mode_o,
  output logic [31:0]   post_div0_o,
  output logic [31:0]   main_pll_o
);
  localparam int IW = AW - 2;
  localparam logic [NREG-1:0] RECOMP = recompute_mask();

  logic [NREG-1:0]         hit;
  logic                    id_hit;
  logic [NREG-1:0][DW-1:0] q;
  logic [DW-1:0]           rdata_d;
  logic                    boot_q;
  logic                    recomp_wr;

  clkctl_decode #(.IW(IW)) u_dec (
    .idx_i   (addr_i),
    .hit_o   (hit),
    .id_hit_o(id_hit)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (slot_writable(g)) begin : g_rw
      clkctl_slot_reg #(
        .DW   (DW),
        .RST  (slot_rst(g)),
        .WMASK(slot_wmask(g)),
        .SETM (slot_setmask(g))
      ) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (we_i & hit[g]),
        .wdata_i(wdata_i),
        .q_o    (q[g])
      );
    end else begin : g_ro
      assign q[g] = slot_rst(g);
    end
  end

  clkctl_rdmux u_mux (
    .hit_i   (hit),
    .id_hit_i(id_hit),
    .q_i     (q),
    .rdata_o (rdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rdata_d;
  end

  assign recomp_wr = we_i & |(hit & RECOMP);

  // boot_q yields the single post-reset recompute request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q       <= 1'b1;
      clk_update_o <= 1'b0;
    end else begin
      boot_q       <= 1'b0;
      clk_update_o <= recomp_wr | boot_q;
    end
  end

  assign mode_o      = q[S_MODE];
  assign post_div0_o = q[S_DIVA];
  assign main_pll_o  = q[S_PLLM];

  a_r2_mode_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[MODE_FORCE_BIT]);
  a_r10_pulse_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recomp_wr |=> clk_update_o);
  // R5 R7: pulse only from a recompute write or leaving reset
  a_r5_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_update_o |-> ($past(recomp_wr) || $past(boot_q)));
  a_r6_id_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && id_hit) |=> (rdata_o == ID_VAL));
  a_r7_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !id_hit && hit == '0) |=> (rdata_o == '0));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/clkctl_regs_bench.sv
module clkctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        upd;
  logic [31:0] mode, div0, pll0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] mdl [0:23];

  always #5 clk = ~clk;

  clkctl_regs u_clkctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .clk_update_o(upd), .mode_o(mode),
    .post_div0_o(div0), .main_pll_o(pll0)
  );

  function automatic bit mapped(int i);
    return i == 0 || i == 1 || i == 2 || i == 4 || i == 6 ||
           i == 8 || i == 9 || i == 10 || i == 23;
  endfunction

  function automatic bit recomp(int i);
    return i == 0 || i == 1 || i == 2 || i == 4 || i == 6;
  endfunction

  function automatic logic [31:0] exp_store(int i, logic [31:0] d, logic [31:0] old);
    case (i)
      0: return (d & 32'h3B6FDFFF) | 32'h04000000;
      1: return d & 32'hFF9F3FFF;
      4, 6: return d & 32'hBFFF3FFF;
      2, 8, 9, 10: return d;
      default: return old;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int i);
    if (i == 18) return 32'h00004040;
    if (i <= 23 && mapped(i)) return mdl[i];
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 24; i++) mdl[i] = 32'h0;
    mdl[0] = 32'h074B0B7B; mdl[1] = 32'hFF870B48; mdl[2] = 32'h49FCFE7F;
    mdl[4] = 32'h04001800; mdl[6] = 32'h04043001;
    mdl[8] = 32'hFFFFFFFF; mdl[9] = 32'hFFFFFFFF; mdl[10] = 32'hFFFFFFFF;
    mdl[23] = 32'h80209828;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    check(req, mode, mdl[0]);
    check(req, div0, mdl[1]);
    check(req, pll0, mdl[4]);
  endtask

  task automatic bus_write(int i, logic [31:0] d);
    @(negedge clk);
    addr = 10'(i); wdata = d; we = 1'b1; re = 1'b0;
    @(posedge clk); #1;
    we = 1'b0;
    if (i <= 23 && mapped(i)) mdl[i] = exp_store(i, d, mdl[i]);
    check(recomp(i) ? "R10 pulse" : "R5/R7 no pulse", 32'(upd), 32'(recomp(i)));
    check_outs("R10 outputs");
  endtask

  task automatic bus_read(int i, string req);
    @(negedge clk);
    addr = 10'(i); re = 1'b1; we = 1'b0;
    @(posedge clk); #1;
    re = 1'b0;
    check(req, rdata, exp_read(i));
    check("R10 no pulse on read", 32'(upd), 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        done = 1;
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset pulse low", 32'(upd), 32'h0);
    check_outs("R1 reset outputs");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R11 boot pulse", 32'(upd), 32'h1);
    @(posedge clk); #1;
    check("R11 boot pulse single", 32'(upd), 32'h0);

    for (int i = 0; i < 24; i++) bus_read(i, "R1 reset readback");

    bus_write(0, 32'h00000000);
    bus_read(0, "R2 mode force");
    bus_write(0, 32'hFFFFFFFF);
    bus_read(0, "R2 mode mask");
    bus_write(1, 32'hFFFFFFFF);
    bus_read(1, "R3 diva mask");
    bus_write(2, 32'h12345678);
    bus_read(2, "R3 divb full");
    bus_write(4, 32'hFFFFFFFF);
    bus_read(4, "R4 main pll mask");
    bus_write(6, 32'h40C0C000);
    bus_read(6, "R4 aux pll mask");
    bus_write(9, 32'h0);
    bus_read(9, "R5 gate store");
    bus_write(18, 32'hDEADBEEF);
    bus_read(18, "R6 id constant");
    bus_write(23, 32'h0);
    bus_read(23, "R8 read-only");
    bus_write(3, 32'hA5A5A5A5);
    bus_read(3, "R7 unmapped");
    bus_write(1023, 32'h5A5A5A5A);
    bus_read(1023, "R7 top index");
    for (int i = 0; i < 24; i++) bus_read(i, "R7 no side effect");

    // R9: read and write together return old contents
    @(negedge clk);
    addr = 10'd2; wdata = 32'hCAFEF00D; we = 1'b1; re = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; re = 1'b0;
    check("R9 read before write", rdata, mdl[2]);
    mdl[2] = 32'hCAFEF00D;
    held = rdata;
    @(negedge clk); addr = 10'd8;
    @(posedge clk); #1;
    check("R9 hold while idle", rdata, held);
    bus_read(2, "R9 new value");

    // R10: back-to-back recompute writes
    bus_write(4, 32'h0);
    bus_write(1, 32'h0);
    bus_read(4, "R4 zero write");

    for (int n = 0; n < 400; n++) begin
      int i;
      logic [31:0] d;
      case ($urandom % 4)
        0: i = int'($urandom % 24);
        1: i = int'($urandom % 1024);
        default: begin
          int pick;
          pick = int'($urandom % 10);
          i = (pick == 9) ? 18 : ((pick == 8) ? 23 : slot_pick(pick));
        end
      endcase
      d = $urandom;
      if ($urandom % 2 == 0) bus_write(i, d);
      else bus_read(i, "R1-model random read");
    end
    for (int i = 0; i < 24; i++) bus_read(i, "R3 final sweep");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int slot_pick(int p);
    case (p)
      0: return 0; 1: return 1; 2: return 2; 3: return 4;
      4: return 6; 5: return 8; 6: return 9; default: return 10;
    endcase
  endfunction
endmodule